// File: doc/BRIEF.md
# I2C Start/Stop Condition Sequencer

This block sits inside an I2C master controller and turns one status-register write into a START or a STOP condition on the bus. The write carries three control bits: master, transmit and busy. It is acted on only while the interface-enable bit is set. With master and transmit both set, busy=1 requests a START and busy=0 requests a STOP. The block then drives active-high pull-down enables for SCL and SDA through a setup phase and a hold phase. Each phase lasts an exact number of clock cycles, and the speed-mode input chooses between a standard and a high-speed set of counts. The counts are latched when the request is accepted.

The bus-busy flag is updated a fixed, mode-dependent number of cycles after the write. When a START completes, SCL is pulled low and a one-cycle hand-off pulse tells the byte-clocking engine to begin. In the same cycle the 3-bit bit counter is cleared. The byte engine advances that counter with a tick input while no condition is running. After the START, both lines stay pulled low for the byte engine until a STOP is accepted. A released line reads back as 1.

Top module: `i2c_cond_gen`

## Requirements
- R1: During reset and directly after it, neither line is pulled, both line read-backs are 1, the busy flag is 0, the bit counter is 0 and no sequence is active.
- R2: A write with interface-enable=1, master=1 and transmit=1 is accepted: the active output is 1 from the cycle after the write edge. busy=1 selects a START and busy=0 selects a STOP.
- R3: A write with master=0 or transmit=0, or a write made while interface-enable is 0, starts no sequence and leaves both line enables and the busy flag unchanged.
- R4: A START in standard mode leaves SDA released for 17 cycles from the write edge, then pulls SDA low for 20 cycles while SCL stays released.
- R5: A START in high-speed mode uses 7 setup cycles and 10 hold cycles, with the same line pattern as R4.
- R6: A STOP releases SCL and holds SDA low for the setup count. It then releases SDA for the hold count, and the block returns to idle with both lines released.
- R7: The busy flag takes its new value (1 for START, 0 for STOP) exactly 12 cycles after the write edge in standard mode, or 6 cycles after it in high-speed mode, and changes at no other time.
- R8: At the end of a START, SCL is pulled low and the hand-off output is 1 for exactly one cycle. In that same cycle the bit counter reads 0. Both lines then stay pulled low until a STOP is accepted.
- R9: A request that arrives while a sequence is running is ignored. The running sequence completes with its own timing and its own condition.
- R10: While idle, each cycle with the tick input high increments the bit counter, and the counter wraps from 7 to 0.
- R11: Each line read-back output is 1 when its pull-down enable is 0, and 0 when the enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fast_mode | input | 1 | 1 selects high-speed counts, 0 selects standard counts |
| if_enable | input | 1 | Interface-enable control bit |
| wr_stat | input | 1 | Status-register write strobe |
| wr_master | input | 1 | Master bit of the written value |
| wr_xmit | input | 1 | Transmit bit of the written value |
| wr_busy | input | 1 | Busy bit of the written value (1 requests START, 0 requests STOP) |
| bit_tick | input | 1 | Bit-counter advance from the byte engine |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| scl_line | output | 1 | Read-back of SCL |
| sda_line | output | 1 | Read-back of SDA |
| bus_busy | output | 1 | Bus-busy flag |
| bit_cnt | output | BITCNT_W (3) | Bit counter |
| byte_go | output | 1 | One-cycle hand-off to the byte engine after a START |
| seq_active | output | 1 | A condition sequence is running |

## Verification
The bench builds the block with its default parameters: 17/20/12 standard counts, 7/10/6 high-speed counts, the high-speed variant enabled and a 3-bit counter. These values bring both timing sets within reach of one run, so every line edge and every busy-flag edge is checked cycle by cycle in both modes. With a 3-bit counter, ten ticks are enough to show the wrap. Because the busy delay is shorter than setup plus hold, the flag is seen to move in the middle of each sequence, and a second request can be placed inside a running START to show it is ignored.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_HOLD  = 2'd2,
      PH_DONE  = 2'd3
   } phase_e;

   typedef enum logic {
      COND_STOP  = 1'b0,
      COND_START = 1'b1
   } cond_e;

   typedef struct packed {
      logic  valid;
      cond_e kind;
   } cond_req_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cond_timing_sel.sv
module cond_timing_sel #(
   parameter int CNT_W      = 5,
   parameter int STD_SETUP  = 17,
   parameter int STD_HOLD   = 20,
   parameter int STD_BUSY   = 12,
   parameter int FAST_SETUP = 7,
   parameter int FAST_HOLD  = 10,
   parameter int FAST_BUSY  = 6,
   parameter bit HAS_FAST   = 1'b1
) (
   input  logic             fast_mode,
   output logic [CNT_W-1:0] setup_len,
   output logic [CNT_W-1:0] hold_len,
   output logic [CNT_W-1:0] busy_len
);
   generate
      if (HAS_FAST) begin : g_two_speed
         always_comb begin
            if (fast_mode) begin
               setup_len = CNT_W'(FAST_SETUP);
               hold_len  = CNT_W'(FAST_HOLD);
               busy_len  = CNT_W'(FAST_BUSY);
            end else begin
               setup_len = CNT_W'(STD_SETUP);
               hold_len  = CNT_W'(STD_HOLD);
               busy_len  = CNT_W'(STD_BUSY);
            end
         end
      end else begin : g_std_only
         logic unused_fast;
         assign unused_fast = fast_mode;
         assign setup_len   = CNT_W'(STD_SETUP);
         assign hold_len    = CNT_W'(STD_HOLD);
         assign busy_len    = CNT_W'(STD_BUSY);
      end
   endgenerate
endmodule

// File: rtl/cond_req_decode.sv
module cond_req_decode
   import i2c_cond_pkg::*;
(
   input  logic      wr_stat,
   input  logic      wr_master,
   input  logic      wr_xmit,
   input  logic      wr_busy,
   input  logic      if_enable,
   input  logic      seq_idle,
   output cond_req_t req
);
   always_comb begin
      req.valid = wr_stat & if_enable & wr_master & wr_xmit & seq_idle;
      req.kind  = wr_busy ? COND_START : COND_STOP;
   end
endmodule

// File: rtl/cond_seq_fsm.sv
module cond_seq_fsm
   import i2c_cond_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cond_req_t        req,
   input  logic [CNT_W-1:0] setup_len,
   input  logic [CNT_W-1:0] hold_len,
   output phase_e           phase,
   output cond_e            kind_q,
   output logic             start_finish
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] setup_q;
   logic [CNT_W-1:0] hold_q;
   logic             setup_last;
   logic             hold_last;

   assign setup_last   = (cnt == setup_q - CNT_W'(1));
   assign hold_last    = (cnt == hold_q - CNT_W'(1));
   assign start_finish = (phase == PH_HOLD) && hold_last && (kind_q == COND_START);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         kind_q  <= COND_STOP;
         setup_q <= '0;
         hold_q  <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (req.valid) begin
                  phase   <= PH_SETUP;
                  cnt     <= '0;
                  kind_q  <= req.kind;
                  setup_q <= setup_len;
                  hold_q  <= hold_len;
               end
            end
            PH_SETUP: begin
               if (setup_last) begin
                  phase <= PH_HOLD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            PH_HOLD: begin
               if (hold_last) begin
                  phase <= (kind_q == COND_START) ? PH_DONE : PH_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R4/R5: the phase counter never passes the latched length
   assert_setup_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SETUP) |-> (cnt < setup_q));
   assert_hold_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD) |-> (cnt < hold_q));
   // R9: a running sequence keeps its condition
   assert_kind_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE) |=> $stable(kind_q) || (phase == PH_SETUP && $past(phase) == PH_IDLE));
endmodule

// File: rtl/busy_tracker.sv
module busy_tracker
   import i2c_cond_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cond_req_t        req,
   input  logic [CNT_W-1:0] busy_len,
   output logic             bus_busy
);
   logic             running;
   logic [CNT_W-1:0] age;
   logic [CNT_W-1:0] len_q;
   cond_e            kind_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         age      <= '0;
         len_q    <= '0;
         kind_q   <= COND_STOP;
         bus_busy <= 1'b0;
      end else if (req.valid) begin
         running <= 1'b1;
         age     <= '0;
         len_q   <= busy_len;
         kind_q  <= req.kind;
      end else if (running) begin
         if (age == len_q - CNT_W'(1)) begin
            running  <= 1'b0;
            bus_busy <= (kind_q == COND_START);
         end else begin
            age <= age + CNT_W'(1);
         end
      end
   end

   // R7: the flag moves only at the end of a timed window
   assert_busy_moves_timed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bus_busy) |-> $past(running));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
   import i2c_cond_pkg::*;
#(
   parameter int STD_SETUP  = 17,
   parameter int STD_HOLD   = 20,
   parameter int STD_BUSY   = 12,
   parameter int FAST_SETUP = 7,
   parameter int FAST_HOLD  = 10,
   parameter int FAST_BUSY  = 6,
   parameter bit HAS_FAST   = 1'b1,
   parameter int BITCNT_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fast_mode,
   input  logic                if_enable,
   input  logic                wr_stat,
   input  logic                wr_master,
   input  logic                wr_xmit,
   input  logic                wr_busy,
   input  logic                bit_tick,
   output logic                scl_pull,
   output logic                sda_pull,
   output logic                scl_line,
   output logic                sda_line,
   output logic                bus_busy,
   output logic [BITCNT_W-1:0] bit_cnt,
   output logic                byte_go,
   output logic                seq_active
);
   localparam int MAX_LEN = max_of(max_of(max_of(STD_SETUP, STD_HOLD), STD_BUSY),
                                   max_of(max_of(FAST_SETUP, FAST_HOLD), FAST_BUSY));
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (STD_SETUP < 1 || STD_HOLD < 1 || STD_BUSY < 1 ||
          FAST_SETUP < 1 || FAST_HOLD < 1 || FAST_BUSY < 1) begin : g_bad_len
         $error("all condition lengths must be at least one cycle");
      end
      if (STD_BUSY > STD_SETUP + STD_HOLD || FAST_BUSY > FAST_SETUP + FAST_HOLD) begin : g_bad_busy
         $error("busy delay must end inside its condition sequence");
      end
      if (BITCNT_W < 1) begin : g_bad_bitcnt
         $error("bit counter needs at least one bit");
      end
   endgenerate

   logic [CNT_W-1:0] setup_len;
   logic [CNT_W-1:0] hold_len;
   logic [CNT_W-1:0] busy_len;
   cond_req_t        req;
   phase_e           phase;
   cond_e            kind_q;
   logic             start_finish;
   logic             line_hold;

   cond_timing_sel #(
      .CNT_W(CNT_W), .STD_SETUP(STD_SETUP), .STD_HOLD(STD_HOLD), .STD_BUSY(STD_BUSY),
      .FAST_SETUP(FAST_SETUP), .FAST_HOLD(FAST_HOLD), .FAST_BUSY(FAST_BUSY),
      .HAS_FAST(HAS_FAST)
   ) u_timing (
      .fast_mode(fast_mode), .setup_len(setup_len), .hold_len(hold_len), .busy_len(busy_len)
   );

   cond_req_decode u_decode (
      .wr_stat(wr_stat), .wr_master(wr_master), .wr_xmit(wr_xmit), .wr_busy(wr_busy),
      .if_enable(if_enable), .seq_idle(phase == PH_IDLE), .req(req)
   );

   cond_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .setup_len(setup_len), .hold_len(hold_len),
      .phase(phase), .kind_q(kind_q), .start_finish(start_finish)
   );

   busy_tracker #(.CNT_W(CNT_W)) u_busy (
      .clk(clk), .rst_n(rst_n), .req(req), .busy_len(busy_len), .bus_busy(bus_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_hold <= 1'b0;
         bit_cnt   <= '0;
      end else begin
         if (phase == PH_DONE)
            line_hold <= 1'b1;
         else if (req.valid && req.kind == COND_STOP)
            line_hold <= 1'b0;
         if (start_finish)
            bit_cnt <= '0;
         else if (bit_tick && phase == PH_IDLE)
            bit_cnt <= bit_cnt + BITCNT_W'(1);
      end
   end

   always_comb begin
      scl_pull = 1'b0;
      sda_pull = 1'b0;
      case (phase)
         PH_IDLE: begin
            scl_pull = line_hold;
            sda_pull = line_hold;
         end
         PH_SETUP: sda_pull = (kind_q == COND_STOP);
         PH_HOLD:  sda_pull = (kind_q == COND_START);
         PH_DONE: begin
            scl_pull = 1'b1;
            sda_pull = 1'b1;
         end
         default: ;
      endcase
   end

   assign scl_line   = ~scl_pull;
   assign sda_line   = ~sda_pull;
   assign byte_go    = (phase == PH_DONE);
   assign seq_active = (phase != PH_IDLE);

   // R2/R3: a sequence only starts from an enabled write
   assert_start_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_active) |-> $past(wr_stat && if_enable && wr_master && wr_xmit));
   // R4: SDA only falls during a sequence while SCL is released
   assert_sda_falls_scl_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull) && seq_active && !byte_go) |-> !scl_pull);
   // R8: hand-off is a single pulse with a cleared bit counter
   assert_go_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_go |=> !byte_go);
   assert_go_bitcnt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      byte_go |-> (bit_cnt == '0));
endmodule

// File: tb/tb_i2c_cond_gen.sv
`timescale 1ns/1ps
module tb_i2c_cond_gen;
   logic       clk = 1'b0;
   logic       rst_n, fast_mode, if_enable, wr_stat, wr_master, wr_xmit, wr_busy, bit_tick;
   logic       scl_pull, sda_pull, scl_line, sda_line, bus_busy, byte_go, seq_active;
   logic [2:0] bit_cnt;
   int         n_checks = 0;
   int         n_errors = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   i2c_cond_gen dut (
      .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .if_enable(if_enable),
      .wr_stat(wr_stat), .wr_master(wr_master), .wr_xmit(wr_xmit), .wr_busy(wr_busy),
      .bit_tick(bit_tick), .scl_pull(scl_pull), .sda_pull(sda_pull), .scl_line(scl_line),
      .sda_line(sda_line), .bus_busy(bus_busy), .bit_cnt(bit_cnt), .byte_go(byte_go),
      .seq_active(seq_active)
   );

   // vector fields {en, master, xmit, busy, accepted}
   localparam logic [4:0] VEC [8] = '{
      5'b0_1_1_1_0, 5'b1_0_1_1_0, 5'b1_1_0_1_0, 5'b1_0_0_0_0,
      5'b1_1_1_1_1, 5'b1_1_0_0_0, 5'b0_1_1_0_0, 5'b1_1_1_0_1
   };

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge (k = 0)
   task automatic do_write(input bit m, input bit x, input bit b);
      wr_master = m; wr_xmit = x; wr_busy = b; wr_stat = 1'b1;
      @(negedge clk);
      wr_stat = 1'b0;
   endtask

   task automatic trace(input bit start, input bit fast);
      int s, h, b;
      string tag;
      s = fast ? 7 : 17;
      h = fast ? 10 : 20;
      b = fast ? 6 : 12;
      tag = start ? (fast ? "R5" : "R4") : "R6";
      fast_mode = fast;
      if_enable = 1'b1;
      do_write(1'b1, 1'b1, start);
      for (int k = 0; k <= s + h + 1; k++) begin
         if (k > 0) @(negedge clk);
         if (start) begin
            check(tag, "sda_pull", sda_pull, (k < s) ? 0 : 1);
            check(tag, "scl_pull", scl_pull, (k < s + h) ? 0 : 1);
            check("R8", "byte_go", byte_go, (k == s + h) ? 1 : 0);
            if (k == s + h) check("R8", "bit_cnt", bit_cnt, 0);
            check("R7", "bus_busy start", bus_busy, (k >= b) ? 1 : 0);
            check("R2", "seq_active", seq_active, (k <= s + h) ? 1 : 0);
         end else begin
            check(tag, "sda_pull", sda_pull, (k < s) ? 1 : 0);
            check(tag, "scl_pull", scl_pull, 0);
            check("R7", "bus_busy stop", bus_busy, (k >= b) ? 0 : 1);
            check("R2", "seq_active", seq_active, (k < s + h) ? 1 : 0);
         end
         check("R11", "scl_line", scl_line, !scl_pull);
         check("R11", "sda_line", sda_line, !sda_pull);
      end
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; fast_mode = 1'b0; if_enable = 1'b0; wr_stat = 1'b0;
      wr_master = 1'b0; wr_xmit = 1'b0; wr_busy = 1'b0; bit_tick = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "scl_pull", scl_pull, 0);
      check("R1", "sda_pull", sda_pull, 0);
      check("R1", "lines", {scl_line, sda_line}, 3);
      check("R1", "bus_busy", bus_busy, 0);
      check("R1", "bit_cnt", bit_cnt, 0);
      check("R1", "seq_active", seq_active, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "seq_active after reset", seq_active, 0);

      // R10: ten ticks wrap a 3-bit counter to 2
      bit_tick = 1'b1;
      repeat (10) @(negedge clk);
      bit_tick = 1'b0;
      check("R10", "bit_cnt wrap", bit_cnt, 2);

      trace(1'b1, 1'b0);
      trace(1'b0, 1'b0);
      trace(1'b1, 1'b1);
      trace(1'b0, 1'b1);

      // table walk, standard mode
      fast_mode = 1'b0;
      for (int i = 0; i < 8; i++) begin
         logic sp, dp, bb;
         sp = scl_pull; dp = sda_pull; bb = bus_busy;
         if_enable = VEC[i][4];
         do_write(VEC[i][3], VEC[i][2], VEC[i][1]);
         if (VEC[i][0]) begin
            check("R2", "accept", seq_active, 1);
            repeat (40) @(negedge clk);
            check("R2", "final busy", bus_busy, VEC[i][1]);
            check("R2", "idle again", seq_active, 0);
         end else begin
            check("R3", "no sequence", seq_active, 0);
            repeat (15) @(negedge clk);
            check("R3", "still idle", seq_active, 0);
            check("R3", "scl unchanged", scl_pull, sp);
            check("R3", "sda unchanged", sda_pull, dp);
            check("R3", "busy unchanged", bus_busy, bb);
         end
      end

      // R9: STOP request during a running START is ignored
      if_enable = 1'b1;
      do_write(1'b1, 1'b1, 1'b1);
      @(negedge clk);
      do_write(1'b1, 1'b1, 1'b0);
      repeat (18) @(negedge clk);
      check("R9", "sda still low in hold", sda_pull, 1);
      check("R9", "busy set", bus_busy, 1);
      repeat (18) @(negedge clk);
      check("R9", "sequence ended", seq_active, 0);
      check("R9", "scl held after start", scl_pull, 1);
      check("R9", "busy still set", bus_busy, 1);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule